// File: doc/BRIEF.md
# Modulo 2^n-1 Prefix Adder

This block adds two n-bit residues and returns their sum reduced modulo 2^n-1. It is purely combinational: operands in, result out, with no clock or state. A parallel prefix network of the Brent-Kung shape forms the plain binary sum. The network has a bit-level generate/propagate stage, a carry tree of black, gray and buffer cells, and a sum stage. An excess-one unit then adds one to that sum whenever the tree's full-width group signals show that the end-around carry applies.

The increment is chosen when the raw sum overflows 2^n or lands exactly on 2^n-1. Because of this, zero always comes out as the all-zeros word and the all-ones form never reaches the output. No zero detector stage follows the adder. The width is a parameter and may be any value from 2 to 32, including widths that are not powers of two. Operands are expected to lie in 0 to 2^n-2.

Top module: `ones_mod_adder`

## Requirements
- R1: For operands a and b in 0..2^n-2, `sum_o` equals (a+b) mod (2^n-1).
- R2: The output is never the all-ones word. A pair whose raw sum is exactly 2^n-1, such as 1 + (2^n-2), yields the all-zeros word.
- R3: When a+b is 2^n or larger, the output is the low n bits of a+b plus one. For example, (2^n-2)+(2^n-2) yields 2^n-3.
- R4: 0 + 0 yields 0.
- R5: When a+b is below 2^n-1, the output equals a+b unchanged.
- R6: The behaviour of R1 to R5 holds at widths that are not powers of two, with the tree positions that have no partner passed through by buffer cells.
- R7: The increment decision follows from the tree's full-width group generate and full-width group propagate alone. The increment is active exactly when a+b is at least 2^n-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | N | First residue operand, 0..2^N-2 |
| b_i | input | N | Second residue operand, 0..2^N-2 |
| sum_o | output | N | (a_i+b_i) mod (2^N-1), zero encoded as all zeros |

## Verification
Every operand pair is applied at widths 5 and 8. This covers the three regimes a sum can fall into: below 2^n-1 (no increment), exactly 2^n-1 (increment that wraps to zero), and at or above 2^n (end-around carry). A defect in any one path shows up apart from the others. Widths 13 and 32 get the corner pairs 0+0, (2^n-2)+1 and (2^n-2)+(2^n-2), plus pseudo-random pairs. This exposes tree wiring faults that only appear at depth or at non-power-of-two sizes. Each result is compared with a modulo reference computed in 64-bit arithmetic.

// File: rtl/ones_mod_pkg.sv
// Package: shared cell kinds and Brent-Kung topology functions for the
// modulo 2^n-1 adder. Assumes widths of 2..32 bits.
package ones_mod_pkg;

    // Kind of prefix cell placed at one tree node.
    typedef enum logic [1:0] {
        CELL_BUF   = 2'd0,
        CELL_GRAY  = 2'd1,
        CELL_BLACK = 2'd2
    } cell_kind_e;

    // Node i combines in the up-sweep at level l when i+1 is a multiple of 2^(l+1).
    function automatic bit bk_up_node(input int i, input int l);
        return ((i + 1) % (1 << (l + 1))) == 0;
    endfunction

    // Node i combines in the down-sweep at level l when i+1 = m*2^(l+1)+2^l, m >= 1.
    function automatic bit bk_down_node(input int i, input int l);
        return ((i + 1) > (1 << (l + 1))) &&
               (((i + 1) % (1 << (l + 1))) == (1 << l));
    endfunction

endpackage

// File: rtl/ones_mod_prep.sv
// Module: bitwise preprocessing. Forms generate (AND) and propagate (XOR)
// per bit position. Pure combinational; no assumptions on operand range.
module ones_mod_prep #(
    parameter int N = 8
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    output logic [N-1:0] gen_o,
    output logic [N-1:0] prop_o
);
    // Per-bit generate and propagate.
    always_comb begin
        gen_o  = a_i & b_i;
        prop_o = a_i ^ b_i;
    end
endmodule

// File: rtl/ones_mod_cell.sv
// Module: one prefix cell. KIND selects black (generate and propagate),
// gray (generate only, propagate forwarded from the upper input) or buffer
// (upper input passed through). Assumes hi covers bits above lo.
module ones_mod_cell
    import ones_mod_pkg::*;
#(
    parameter cell_kind_e KIND = CELL_BLACK
) (
    input  logic g_hi_i,
    input  logic p_hi_i,
    input  logic g_lo_i,
    input  logic p_lo_i,
    output logic g_o,
    output logic p_o
);
    generate
        if (KIND == CELL_BLACK) begin : g_black
            // Combine both group signals.
            always_comb begin
                g_o = g_hi_i | (p_hi_i & g_lo_i);
                p_o = p_hi_i & p_lo_i;
            end
        end else if (KIND == CELL_GRAY) begin : g_gray
            // Combine generate only; propagate output is not a group value.
            always_comb begin
                g_o = g_hi_i | (p_hi_i & g_lo_i);
                p_o = p_hi_i | p_lo_i;
            end
        end else begin : g_buf
            // Pass the upper node through; lower node is ignored.
            always_comb begin
                g_o = g_hi_i | (1'b0 & g_lo_i);
                p_o = p_hi_i | (1'b0 & p_lo_i);
            end
        end
    endgenerate
endmodule

// File: rtl/ones_mod_bk_tree.sv
// Module: Brent-Kung prefix carry tree over N bits. Up-sweep over powers of
// two, then a down-sweep fills the remaining prefixes. Produces G[i:0] for
// every i and the full-width group propagate P[N-1:0]. Nodes with no
// partner at a stage are buffer cells. Black cells everywhere except the
// last down-sweep level, where only the top node stays black so that its
// propagate is a true full-width group value. Assumes 2 <= N <= 32.
module ones_mod_bk_tree
    import ones_mod_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] gen_i,
    input  logic [N-1:0] prop_i,
    output logic [N-1:0] grp_g_o,
    output logic         grp_p_all_o
);
    localparam int LVL = $clog2(N);
    localparam int NST = 2 * LVL - 1;

    logic [N-1:0] gs [0:NST];
    logic [N-1:0] ps [0:NST];

    // Stage zero is the bitwise preprocessing result.
    always_comb begin
        gs[0] = gen_i;
        ps[0] = prop_i;
    end

    for (genvar s = 1; s <= NST; s++) begin : g_stage
        localparam bit IS_UP = (s <= LVL);
        localparam int L     = IS_UP ? (s - 1) : (2 * LVL - 1 - s);
        localparam int DIST  = 1 << L;
        for (genvar i = 0; i < N; i++) begin : g_node
            localparam bit ACT = IS_UP ? bk_up_node(i, L) : bk_down_node(i, L);
            localparam int LO  = (ACT && i >= DIST) ? (i - DIST) : i;
            localparam cell_kind_e KIND =
                !ACT ? CELL_BUF :
                (!IS_UP && L == 0 && i != N - 1) ? CELL_GRAY : CELL_BLACK;
            ones_mod_cell #(.KIND(KIND)) u_cell (
                .g_hi_i (gs[s-1][i]),
                .p_hi_i (ps[s-1][i]),
                .g_lo_i (gs[s-1][LO]),
                .p_lo_i (ps[s-1][LO]),
                .g_o    (gs[s][i]),
                .p_o    (ps[s][i])
            );
        end
    end

    // Publish group generates and the full-width group propagate.
    always_comb begin
        grp_g_o     = gs[NST];
        grp_p_all_o = ps[NST][N-1];
    end
endmodule

// File: rtl/ones_mod_excess1.sv
// Module: excess-one unit. Adds one to the first-stage sum through an
// AND-prefix of its bits toggled by XOR, then a 2:1 mux picks the plain or
// incremented sum under inc_i. The all-ones sum increments to zero.
module ones_mod_excess1 #(
    parameter int N = 8
) (
    input  logic [N-1:0] sum_i,
    input  logic         inc_i,
    output logic [N-1:0] sum_o
);
    logic [N-1:0] ones_below;
    logic [N-1:0] sum_plus;

    // Running AND of lower sum bits: toggle mask for the increment.
    always_comb begin
        ones_below[0] = 1'b1;
        for (int k = 1; k < N; k++) begin
            ones_below[k] = ones_below[k-1] & sum_i[k-1];
        end
    end

    // Increment and select.
    always_comb begin
        sum_plus = sum_i ^ ones_below;
        sum_o    = inc_i ? sum_plus : sum_i;
    end
endmodule

// File: rtl/ones_mod_adder.sv
// Module: top of the modulo 2^n-1 adder. Operands must lie in 0..2^N-2.
// The end-around carry is applied by the excess-one unit whenever the full
// group generate or full group propagate is set, so zero leaves as all zeros.
module ones_mod_adder #(
    parameter int N = 8
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    output logic [N-1:0] sum_o
);
    logic [N-1:0] gen_w;
    logic [N-1:0] prop_w;
    logic [N-1:0] grp_g;
    logic         grp_p_all;
    logic [N-1:0] carry_in;
    logic [N-1:0] raw_sum;
    logic         inc_sel;

    ones_mod_prep #(.N(N)) u_prep (
        .a_i    (a_i),
        .b_i    (b_i),
        .gen_o  (gen_w),
        .prop_o (prop_w)
    );

    ones_mod_bk_tree #(.N(N)) u_tree (
        .gen_i       (gen_w),
        .prop_i      (prop_w),
        .grp_g_o     (grp_g),
        .grp_p_all_o (grp_p_all)
    );

    // Carry into each bit from the prefix below it; carry-in of bit 0 is zero.
    always_comb begin
        carry_in = {grp_g[N-2:0], 1'b0};
        raw_sum  = prop_w ^ carry_in;
    end

    // Increment when the sum overflows 2^N or equals 2^N-1.
    always_comb begin
        inc_sel = grp_g[N-1] | grp_p_all;
    end

    ones_mod_excess1 #(.N(N)) u_inc (
        .sum_i (raw_sum),
        .inc_i (inc_sel),
        .sum_o (sum_o)
    );
endmodule

// File: rtl/ones_mod_adder_chk.sv
// Checker: combinational properties of the modulo adder, applied only to
// known in-range operands. Bound into every ones_mod_adder instance.
module ones_mod_adder_chk #(
    parameter int N = 8
) (
    input logic [N-1:0] a_i,
    input logic [N-1:0] b_i,
    input logic [N-1:0] sum_o,
    input logic         inc_i
);
    localparam logic [N:0] MODV = {1'b0, {N{1'b1}}};
    localparam logic [N:0] TWON = {1'b1, {N{1'b0}}};

    logic [N:0] raw;
    logic [N:0] refv;
    logic       live;

    // Reference sum and operand validity.
    always_comb begin
        raw  = {1'b0, a_i} + {1'b0, b_i};
        refv = (raw >= MODV) ? (raw - MODV) : raw;
        live = !$isunknown({a_i, b_i, sum_o, inc_i}) &&
               ({1'b0, a_i} < MODV) && ({1'b0, b_i} < MODV);
    end

    // Property checks on each settled input pair.
    always_comb begin
        if (live) begin
            a_r1_mod_sum: assert ({1'b0, sum_o} == refv)
                else $error("R1 modulo sum mismatch");
            a_r2_no_all_ones: assert (sum_o != {N{1'b1}})
                else $error("R2 all-ones zero emitted");
            a_r3_wrap_increments: assert (!(raw >= TWON) || inc_i)
                else $error("R3 overflow without increment");
            a_r5_small_no_increment: assert (!(raw < MODV) || (!inc_i && {1'b0, sum_o} == raw))
                else $error("R5 small sum altered");
            a_r7_inc_threshold: assert (inc_i == (raw >= MODV))
                else $error("R7 increment decision wrong");
        end
    end
endmodule

bind ones_mod_adder ones_mod_adder_chk #(.N(N)) u_chk (
    .a_i   (a_i),
    .b_i   (b_i),
    .sum_o (sum_o),
    .inc_i (inc_sel)
);

// File: tb/ones_mod_adder_tb.sv
// Bench: exhaustive sweeps at widths 5 and 8, corners plus random pairs at
// widths 13 and 32, each checked against a 64-bit modulo reference.
module ones_mod_adder_tb;
    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [4:0]  a5, b5, s5;
    logic [7:0]  a8, b8, s8;
    logic [12:0] a13, b13, s13;
    logic [31:0] a32, b32, s32;

    ones_mod_adder #(.N(5))  u_dut     (.a_i(a5),  .b_i(b5),  .sum_o(s5));
    ones_mod_adder #(.N(8))  u_dut_w8  (.a_i(a8),  .b_i(b8),  .sum_o(s8));
    ones_mod_adder #(.N(13)) u_dut_w13 (.a_i(a13), .b_i(b13), .sum_o(s13));
    ones_mod_adder #(.N(32)) u_dut_w32 (.a_i(a32), .b_i(b32), .sum_o(s32));

    // Compare one result with the modulo reference and tag the regime.
    task automatic judge(input int w, input longint a, input longint b, input longint got);
        longint m, raw, exp;
        string  tag;
        m   = (longint'(1) << w) - 1;
        raw = a + b;
        exp = raw % m;
        if (a == 0 && b == 0)            tag = "R4";
        else if (raw == m)               tag = "R2";
        else if (raw > m)                tag = "R3";
        else                             tag = "R5";
        checks++;
        if (got != exp || got == m) begin
            failures++;
            $display("FAIL %s/R1 (R6 width %0d) a=%0d b=%0d actual=%0d expected=%0d",
                     tag, w, a, b, got, exp);
        end
    endtask

    task automatic run5(input longint a, input longint b);
        a5 = a[4:0]; b5 = b[4:0];
        #2;
        judge(5, a, b, longint'(s5));
    endtask

    task automatic run8(input longint a, input longint b);
        a8 = a[7:0]; b8 = b[7:0];
        #2;
        judge(8, a, b, longint'(s8));
    endtask

    task automatic run13(input longint a, input longint b);
        a13 = a[12:0]; b13 = b[12:0];
        #2;
        judge(13, a, b, longint'(s13));
    endtask

    task automatic run32(input longint a, input longint b);
        a32 = a[31:0]; b32 = b[31:0];
        #2;
        judge(32, a, b, longint'(s32));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        longint seed = 64'h1234_5678_9abc_def1;
        a5 = '0; b5 = '0; a8 = '0; b8 = '0;
        a13 = '0; b13 = '0; a32 = '0; b32 = '0;
        @(negedge clk);
        // R4: initial zero pair on every width.
        run5(0, 0); run8(0, 0); run13(0, 0); run32(0, 0);
        // R1 R2 R3 R5 R6: every pair at width 5 (non-power-of-two).
        for (int x = 0; x < 31; x++)
            for (int y = 0; y < 31; y++) run5(x, y);
        // R1 R2 R3 R5: every pair at width 8.
        for (int x = 0; x < 255; x++)
            for (int y = 0; y < 255; y++) run8(x, y);
        // R2 R3 R6: corners at widths 13 and 32.
        run13(8190, 1); run13(8190, 8190); run13(1, 8190); run13(4095, 4096);
        run32(64'd4294967294, 1); run32(64'd4294967294, 64'd4294967294);
        run32(64'd2147483648, 64'd2147483647); run32(64'd2147483648, 64'd2147483648);
        // R1 R6: pseudo-random pairs.
        for (int k = 0; k < 2000; k++) begin
            longint ra, rb;
            seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
            ra = (seed >>> 33) & 64'h1FFF;  if (ra == 8191) ra = 8190;
            rb = (seed >>> 20) & 64'h1FFF;  if (rb == 8191) rb = 8190;
            run13(ra, rb);
            seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
            ra = (seed >>> 31) & 64'hFFFF_FFFF; if (ra == 64'hFFFF_FFFF) ra = ra - 1;
            seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
            rb = (seed >>> 31) & 64'hFFFF_FFFF; if (rb == 64'hFFFF_FFFF) rb = rb - 1;
            run32(ra, rb);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule